// File: doc/BRIEF.md
# Serial Flash Power-Mode Front End

This block sits at the front of a serial flash slave and decides whether the device is awake. It samples an SPI-style byte stream (mode 0: data captured on rising serial-clock edges, most significant bit first) while chip select is held low. It also tracks a four-state power machine. A dedicated sleep opcode puts the device into its lowest-power state, but only if chip select rises exactly on the byte boundary. A separate wake opcode brings the device back and can also return a one-byte identification value. The three pad inputs are brought into a free-running system clock domain through synchronisers, and every delay is counted in that clock.

Downstream command logic sees only an accept strobe that carries the decoded opcode. The strobe fires only for instructions the current mode allows, so the memory engines behind it never see traffic while the part is asleep or changing mode. A busy input from the internal erase, program or write engine blocks sleep entry. The running cycle carries on unaffected.

The power machine has four states:
- `ST_STANDBY` is the normal awake state.
- `ST_ENTER_WAIT` counts down the entry delay.
- `ST_DEEP` is the powered-down state.
- `ST_REL_WAIT` counts down the wake recovery time.

The transitions are:
- STANDBY to ENTER_WAIT on a clean sleep commit.
- ENTER_WAIT to DEEP when the entry timer expires.
- DEEP to REL_WAIT on a wake commit.
- REL_WAIT to STANDBY when the recovery timer expires.
- Every other case holds the current state.

Top module: `dpd_ctrl`

## Requirements
- R1: After reset the block is in standby: `dp_flag` is 0, `sdo_oe` is 0 and no strobe is issued.
- R2: Bits on `sdi` are captured on rising `sck` edges, MSB first. In standby, every 8-bit opcode yields exactly one one-cycle `acc_valid` pulse with `acc_op` equal to that opcode.
- R3: The sleep opcode 0xB9 commits only when `cs_n` rises after exactly 8 clocked bits. With any other bit count the instruction is discarded and the block stays in standby.
- R4: After a committed sleep instruction, `dp_flag` rises exactly `TDP_CYC + 3` system-clock edges after `cs_n` goes high. This is two synchroniser stages, one commit edge and the timer.
- R5: A sleep commit while `busy` is 1 is refused, and the block stays in standby.
- R6: During the entry countdown and during the wake recovery, no instruction produces a strobe or changes the mode.
- R7: In deep power-down only the wake opcode 0xAB produces a strobe. Every other opcode, including 0xB9, is dropped and `dp_flag` stays 1.
- R8: In deep power-down, 0xAB followed by a rise of `cs_n` after at least 8 bits clears `dp_flag` within 3 edges. After `TRES_CYC` further cycles the block accepts instructions again.
- R9: After an accepted 0xAB and 24 dummy bits, `sdo` presents `SIG` MSB first, updated on falling `sck` edges and repeating every 8 bits. `sdo_oe` is 1 only during this phase and drops when `cs_n` goes high.
- R10: A rise of `cs_n` part-way through a byte aborts it. The next transaction starts counting from bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select pad, active low |
| sck | input | 1 | Serial clock pad |
| sdi | input | 1 | Serial data input pad |
| busy | input | 1 | Internal erase/program/write cycle in progress |
| sdo | output | 1 | Serial data output value |
| sdo_oe | output | 1 | Output enable for `sdo`; pad is high impedance when 0 |
| dp_flag | output | 1 | Device is in deep power-down |
| acc_valid | output | 1 | One-cycle accept strobe for an allowed opcode |
| acc_op | output | 8 | Opcode carried with `acc_valid` |

## Verification
The bench sweeps every opcode in standby and in deep power-down. A gate that leaks a strobe while asleep, or drops a legal one while awake, shows up in the pulse count. It raises chip select after every bit count from 1 to 16 with the sleep pattern, which exposes a commit test that accepts "at least 8" or lets bits carry across an aborted byte. It measures the exact edge on which the sleep flag rises, so an off-by-one timer load is visible, and it sends commands during both countdowns to show that they are neither accepted nor able to change the mode. It reads the signature across two repetitions and checks the output enable before and after, so a misplaced dummy count or a stuck enable fails.

// File: rtl/dpd_pkg.sv
package dpd_pkg;
    localparam int OPC_BITS    = 8;
    localparam int DUMMY_BYTES = 3;

    localparam logic [OPC_BITS-1:0] OP_SLEEP = 8'hB9;
    localparam logic [OPC_BITS-1:0] OP_WAKE  = 8'hAB;

    typedef enum logic [1:0] {
        ST_STANDBY    = 2'd0,
        ST_ENTER_WAIT = 2'd1,
        ST_DEEP       = 2'd2,
        ST_REL_WAIT   = 2'd3
    } pwr_state_t;
endpackage

// File: rtl/dpd_pin_sync.sv
module dpd_pin_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            chain <= {STAGES{RST_VAL}};
        else
            chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/dpd_spi_front.sv
module dpd_spi_front #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic sdi,
    output logic cs_low,
    output logic cs_rise,
    output logic sck_rise,
    output logic sck_fall,
    output logic sdi_s
);
    localparam int         NPINS   = 3;
    localparam logic [2:0] IDLE_LV = 3'b001;   // bit0 cs idle high, bit1 sck idle low, bit2 sdi

    logic [NPINS-1:0] pins_raw;
    logic [NPINS-1:0] pins_s;
    logic             cs_q;
    logic             sck_q;

    assign pins_raw = {sdi, sck, cs_n};

    for (genvar g = 0; g < NPINS; g++) begin : g_sync
        dpd_pin_sync #(
            .STAGES (SYNC_STAGES),
            .RST_VAL(IDLE_LV[g])
        ) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (pins_raw[g]),
            .dout (pins_s[g])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q  <= 1'b1;
            sck_q <= 1'b0;
        end else begin
            cs_q  <= pins_s[0];
            sck_q <= pins_s[1];
        end
    end

    assign cs_low   = ~pins_s[0];
    assign cs_rise  = pins_s[0] & ~cs_q;
    assign sck_rise = pins_s[1] & ~sck_q;
    assign sck_fall = ~pins_s[1] & sck_q;
    assign sdi_s    = pins_s[2];
endmodule

// File: rtl/dpd_cmd_shifter.sv
module dpd_cmd_shifter
    import dpd_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cs_low,
    input  logic                sck_rise,
    input  logic                sdi_s,
    input  logic                sig_mode,
    output logic [OPC_BITS-1:0] op_next,
    output logic [OPC_BITS-1:0] op_q,
    output logic                op_done,
    output logic [CNT_W-1:0]    bit_cnt
);
    localparam logic [CNT_W-1:0] LAST_OPC  = CNT_W'(OPC_BITS - 1);
    localparam logic [CNT_W-1:0] SIG_FIRST = CNT_W'(OPC_BITS * (1 + DUMMY_BYTES));
    localparam logic [CNT_W-1:0] SIG_LAST  = CNT_W'(OPC_BITS * (2 + DUMMY_BYTES) - 1);
    localparam logic [CNT_W-1:0] CNT_MAX   = {CNT_W{1'b1}};

    logic [OPC_BITS-1:0] shreg;

    assign op_next = {shreg[OPC_BITS-2:0], sdi_s};
    assign op_done = cs_low & sck_rise & (bit_cnt == LAST_OPC);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg   <= '0;
            op_q    <= '0;
            bit_cnt <= '0;
        end else if (!cs_low) begin
            bit_cnt <= '0;
        end else if (sck_rise) begin
            shreg <= op_next;
            if (bit_cnt == LAST_OPC)
                op_q <= op_next;
            if (sig_mode && bit_cnt == SIG_LAST)
                bit_cnt <= SIG_FIRST;
            else if (bit_cnt != CNT_MAX)
                bit_cnt <= bit_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/dpd_power_fsm.sv
module dpd_power_fsm
    import dpd_pkg::*;
#(
    parameter int CNT_W    = 6,
    parameter int TDP_CYC  = 150,
    parameter int TRES_CYC = 150
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cs_rise,
    input  logic                busy,
    input  logic [CNT_W-1:0]    bit_cnt,
    input  logic [OPC_BITS-1:0] op_q,
    input  logic [OPC_BITS-1:0] op_next,
    input  logic                op_done,
    output pwr_state_t          state,
    output logic [$clog2(((TDP_CYC > TRES_CYC) ? TDP_CYC : TRES_CYC) + 1)-1:0] timer,
    output logic                acc_valid,
    output logic [OPC_BITS-1:0] acc_op
);
    localparam int               MAXW    = (TDP_CYC > TRES_CYC) ? TDP_CYC : TRES_CYC;
    localparam int               TW      = $clog2(MAXW + 1);
    localparam logic [CNT_W-1:0] FULL_OP = CNT_W'(OPC_BITS);

    pwr_state_t nxt;
    logic       sleep_commit;
    logic       wake_commit;
    logic       allowed;

    assign sleep_commit = cs_rise && (bit_cnt == FULL_OP) && (op_q == OP_SLEEP) && !busy;
    assign wake_commit  = cs_rise && (bit_cnt >= FULL_OP) && (op_q == OP_WAKE);

    always_comb begin
        nxt = state;
        unique case (state)
            ST_STANDBY:    if (sleep_commit) nxt = ST_ENTER_WAIT;
            ST_ENTER_WAIT: if (timer == '0)  nxt = ST_DEEP;
            ST_DEEP:       if (wake_commit)  nxt = ST_REL_WAIT;
            ST_REL_WAIT:   if (timer == '0)  nxt = ST_STANDBY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_STANDBY;
            timer <= '0;
        end else begin
            state <= nxt;
            if (nxt == ST_ENTER_WAIT && state != ST_ENTER_WAIT)
                timer <= TW'(TDP_CYC - 1);
            else if (nxt == ST_REL_WAIT && state != ST_REL_WAIT)
                timer <= TW'(TRES_CYC - 1);
            else if (timer != '0)
                timer <= timer - 1'b1;
        end
    end

    always_comb begin
        unique case (state)
            ST_STANDBY: allowed = 1'b1;
            ST_DEEP:    allowed = (op_next == OP_WAKE);
            default:    allowed = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_valid <= 1'b0;
            acc_op    <= '0;
        end else begin
            acc_valid <= op_done && allowed;
            if (op_done && allowed)
                acc_op <= op_next;
        end
    end
endmodule

// File: rtl/dpd_sig_out.sv
module dpd_sig_out
    import dpd_pkg::*;
#(
    parameter int                  CNT_W = 6,
    parameter logic [OPC_BITS-1:0] SIG   = 8'h14
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cs_low,
    input  logic                sck_fall,
    input  logic                acc_valid,
    input  logic [OPC_BITS-1:0] acc_op,
    input  logic [CNT_W-1:0]    bit_cnt,
    output logic                sig_mode,
    output logic                sdo,
    output logic                sdo_oe
);
    localparam logic [CNT_W-1:0] SIG_FIRST = CNT_W'(OPC_BITS * (1 + DUMMY_BYTES));
    localparam int               IW        = $clog2(OPC_BITS);

    logic [IW-1:0] idx;
    assign idx = IW'(OPC_BITS - 1) - bit_cnt[IW-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sig_mode <= 1'b0;
            sdo      <= 1'b0;
            sdo_oe   <= 1'b0;
        end else if (!cs_low) begin
            sig_mode <= 1'b0;
            sdo_oe   <= 1'b0;
        end else begin
            if (acc_valid && acc_op == OP_WAKE)
                sig_mode <= 1'b1;
            if (sck_fall && sig_mode && bit_cnt >= SIG_FIRST) begin
                sdo_oe <= 1'b1;
                sdo    <= SIG[idx];
            end
        end
    end
endmodule

// File: rtl/dpd_ctrl.sv
module dpd_ctrl
    import dpd_pkg::*;
#(
    parameter int                  SYNC_STAGES = 2,
    parameter int                  CNT_W       = 6,
    parameter int                  TDP_CYC     = 150,
    parameter int                  TRES_CYC    = 150,
    parameter logic [OPC_BITS-1:0] SIG         = 8'h14
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cs_n,
    input  logic                sck,
    input  logic                sdi,
    input  logic                busy,
    output logic                sdo,
    output logic                sdo_oe,
    output logic                dp_flag,
    output logic                acc_valid,
    output logic [OPC_BITS-1:0] acc_op
);
    localparam int MAXW = (TDP_CYC > TRES_CYC) ? TDP_CYC : TRES_CYC;
    localparam int TW   = $clog2(MAXW + 1);

    logic                cs_low, cs_rise, sck_rise, sck_fall, sdi_s;
    logic                sig_mode, op_done;
    logic [OPC_BITS-1:0] op_next, op_q;
    logic [CNT_W-1:0]    bit_cnt;
    pwr_state_t          pwr_state;
    logic [TW-1:0]       fsm_timer;

    dpd_spi_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n    (cs_n),
        .sck     (sck),
        .sdi     (sdi),
        .cs_low  (cs_low),
        .cs_rise (cs_rise),
        .sck_rise(sck_rise),
        .sck_fall(sck_fall),
        .sdi_s   (sdi_s)
    );

    dpd_cmd_shifter #(.CNT_W(CNT_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_low  (cs_low),
        .sck_rise(sck_rise),
        .sdi_s   (sdi_s),
        .sig_mode(sig_mode),
        .op_next (op_next),
        .op_q    (op_q),
        .op_done (op_done),
        .bit_cnt (bit_cnt)
    );

    dpd_power_fsm #(
        .CNT_W   (CNT_W),
        .TDP_CYC (TDP_CYC),
        .TRES_CYC(TRES_CYC)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_rise  (cs_rise),
        .busy     (busy),
        .bit_cnt  (bit_cnt),
        .op_q     (op_q),
        .op_next  (op_next),
        .op_done  (op_done),
        .state    (pwr_state),
        .timer    (fsm_timer),
        .acc_valid(acc_valid),
        .acc_op   (acc_op)
    );

    dpd_sig_out #(.CNT_W(CNT_W), .SIG(SIG)) u_sig (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_low   (cs_low),
        .sck_fall (sck_fall),
        .acc_valid(acc_valid),
        .acc_op   (acc_op),
        .bit_cnt  (bit_cnt),
        .sig_mode (sig_mode),
        .sdo      (sdo),
        .sdo_oe   (sdo_oe)
    );

    assign dp_flag = (pwr_state == ST_DEEP);
endmodule

// File: rtl/dpd_ctrl_checker.sv
module dpd_ctrl_checker
    import dpd_pkg::*;
#(
    parameter int TW = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                busy,
    input  logic                cs_rise,
    input  logic                dp_flag,
    input  logic                sdo_oe,
    input  logic                acc_valid,
    input  logic [OPC_BITS-1:0] acc_op,
    input  pwr_state_t          state,
    input  logic [TW-1:0]       timer
);
    AST_RESET_STANDBY: assert property (@(posedge clk) !rst_n |=> !dp_flag); // R1

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> !acc_valid); // R2

    AST_BUSY_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_rise && busy && state == ST_STANDBY) |=> state == ST_STANDBY); // R5

    AST_FLAG_AFTER_TIMER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dp_flag) |-> $past(timer) == '0); // R4

    AST_WAIT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ENTER_WAIT || state == ST_REL_WAIT) |=> !acc_valid); // R6

    AST_DEEP_WAKE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (dp_flag && acc_valid) |-> acc_op == OP_WAKE); // R7

    AST_OE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        cs_rise |=> !sdo_oe); // R9
endmodule

bind dpd_ctrl dpd_ctrl_checker #(.TW(TW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .cs_rise  (cs_rise),
    .dp_flag  (dp_flag),
    .sdo_oe   (sdo_oe),
    .acc_valid(acc_valid),
    .acc_op   (acc_op),
    .state    (pwr_state),
    .timer    (fsm_timer)
);

// File: tb/dpd_ctrl_bench.sv
module dpd_ctrl_bench;
    localparam int         CLK_PERIOD = 10;
    localparam int         HALF       = 6;
    localparam int         TDP        = 150;
    localparam int         TRES       = 150;
    localparam logic [7:0] SIGV       = 8'h5C;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, sck = 1'b0, sdi = 1'b0, busy = 1'b0;
    logic       sdo, sdo_oe, dp_flag, acc_valid;
    logic [7:0] acc_op;

    int n_checks = 0, n_fail = 0, n_strobe = 0;
    logic [7:0] last_op = 8'h00;

    always #(CLK_PERIOD/2) clk = ~clk;

    dpd_ctrl #(.TDP_CYC(TDP), .TRES_CYC(TRES), .SIG(SIGV)) u_dpd_ctrl (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi), .busy(busy),
        .sdo(sdo), .sdo_oe(sdo_oe), .dp_flag(dp_flag),
        .acc_valid(acc_valid), .acc_op(acc_op)
    );

    always @(negedge clk) if (acc_valid) begin
        n_strobe++;
        last_op = acc_op;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // clock out nbits from the top of pat, optionally reading the signature phase
    task automatic send(input logic [63:0] pat, input int nbits, input bit read_sig);
        @(negedge clk);
        cs_n = 1'b0;
        for (int i = 0; i < nbits; i++) begin
            sdi = pat[63-i];
            wait_clk(HALF);
            if (read_sig) begin
                if (i < 32)
                    check(sdo_oe == 1'b0, "R9", "oe before signature", sdo_oe, 0);
                else begin
                    check(sdo_oe == 1'b1, "R9", "oe in signature", sdo_oe, 1);
                    check(sdo == SIGV[7-((i-32)%8)], "R9", "signature bit", sdo,
                          SIGV[7-((i-32)%8)]);
                end
            end
            sck = 1'b1;
            wait_clk(HALF);
            sck = 1'b0;
        end
        wait_clk(HALF);
        cs_n = 1'b1;
    endtask

    task automatic enter_deep();
        send({8'hB9, 56'h0}, 8, 1'b0);
        wait_clk(TDP + 10);
    endtask

    task automatic wake();
        send({8'hAB, 56'h0}, 8, 1'b0);
        wait_clk(TRES + 10);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "WDOG", "watchdog expired", 0, 1);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        int s0;
        wait_clk(4);
        check(dp_flag == 1'b0, "R1", "flag in reset", dp_flag, 0);
        check(sdo_oe == 1'b0, "R1", "oe in reset", sdo_oe, 0);
        rst_n = 1'b1;
        wait_clk(5);
        check(n_strobe == 0, "R1", "no strobe after reset", n_strobe, 0);
        check(dp_flag == 1'b0, "R1", "standby after reset", dp_flag, 0);

        // R2: every opcode except sleep in standby
        for (int op = 0; op < 256; op++) begin
            if (op == 8'hB9) continue;
            s0 = n_strobe;
            send({op[7:0], 56'h0}, 8, 1'b0);
            wait_clk(6);
            check(n_strobe == s0 + 1, "R2", "strobe count", n_strobe - s0, 1);
            check(last_op == op[7:0], "R2", "strobe opcode", last_op, op);
            check(dp_flag == 1'b0, "R2", "stays standby", dp_flag, 0);
        end

        // R10: aborted half byte then full opcode
        s0 = n_strobe;
        send({8'hF0, 56'h0}, 4, 1'b0);
        send({8'h03, 56'h0}, 8, 1'b0);
        wait_clk(6);
        check(n_strobe == s0 + 1, "R10", "one strobe after abort", n_strobe - s0, 1);
        check(last_op == 8'h03, "R10", "opcode restarts", last_op, 8'h03);

        // R3: sleep pattern with wrong bit counts
        for (int n = 1; n <= 16; n++) begin
            if (n == 8) continue;
            send({8{8'hB9}}, n, 1'b0);
            wait_clk(TDP + 10);
            check(dp_flag == 1'b0, "R3", $sformatf("no entry at %0d bits", n), dp_flag, 0);
        end

        // R5: busy refuses entry
        busy = 1'b1;
        send({8'hB9, 56'h0}, 8, 1'b0);
        wait_clk(6);
        busy = 1'b0;
        wait_clk(TDP + 10);
        check(dp_flag == 1'b0, "R5", "busy blocks sleep", dp_flag, 0);

        // R4: exact entry edge
        send({8'hB9, 56'h0}, 8, 1'b0);
        repeat (TDP + 2) @(posedge clk);
        @(negedge clk);
        check(dp_flag == 1'b0, "R4", "flag before delay", dp_flag, 0);
        @(posedge clk);
        @(negedge clk);
        check(dp_flag == 1'b1, "R4", "flag at delay", dp_flag, 1);

        // R7: sweep non-wake opcodes while asleep
        for (int op = 0; op < 256; op++) begin
            if (op == 8'hAB) continue;
            s0 = n_strobe;
            send({op[7:0], 56'h0}, 8, 1'b0);
            wait_clk(6);
            check(n_strobe == s0, "R7", "no strobe in deep", n_strobe - s0, 0);
            check(dp_flag == 1'b1, "R7", "stays deep", dp_flag, 1);
        end

        // R8 + R9: wake with signature readout from deep
        s0 = n_strobe;
        send({8'hAB, 56'h0}, 48, 1'b1);
        wait_clk(4);
        check(n_strobe == s0 + 1, "R8", "wake strobe", n_strobe - s0, 1);
        check(last_op == 8'hAB, "R8", "wake opcode", last_op, 8'hAB);
        check(dp_flag == 1'b0, "R8", "flag cleared", dp_flag, 0);
        check(sdo_oe == 1'b0, "R9", "oe off after cs high", sdo_oe, 0);

        // R6: commands during recovery are dropped
        s0 = n_strobe;
        send({8'hB9, 56'h0}, 8, 1'b0);
        wait_clk(TRES + TDP + 10);
        check(n_strobe == s0, "R6", "no strobe in recovery", n_strobe - s0, 0);
        check(dp_flag == 1'b0, "R6", "recovery sleep ignored", dp_flag, 0);
        s0 = n_strobe;
        send({8'h05, 56'h0}, 8, 1'b0);
        wait_clk(6);
        check(n_strobe == s0 + 1, "R8", "accepts after recovery", n_strobe - s0, 1);

        // R9: signature in standby
        send({8'hAB, 56'h0}, 48, 1'b1);
        wait_clk(6);
        check(sdo_oe == 1'b0, "R9", "oe off in standby read", sdo_oe, 0);

        // R6: commands during entry countdown are dropped
        send({8'hB9, 56'h0}, 8, 1'b0);
        s0 = n_strobe;
        send({8'hAB, 56'h0}, 8, 1'b0);
        wait_clk(TDP + 10);
        check(n_strobe == s0, "R6", "no strobe in countdown", n_strobe - s0, 0);
        check(dp_flag == 1'b1, "R6", "countdown not cancelled", dp_flag, 1);

        // R1: reset from deep lands in standby
        rst_n = 1'b0;
        wait_clk(3);
        check(dp_flag == 1'b0, "R1", "reset leaves deep", dp_flag, 0);
        rst_n = 1'b1;
        wait_clk(3);
        enter_deep();
        check(dp_flag == 1'b1, "R4", "re-entry", dp_flag, 1);
        wake();
        check(dp_flag == 1'b0, "R8", "plain wake", dp_flag, 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule